// File: doc/BRIEF.md
# Dual Timer Register Wrapper with Interrupt Test Override

This block sits on a 32-bit APB-style register bus and holds two timer channels behind one 4 KB window. It decodes the bus address into per-channel register accesses. Address bit 5 selects the channel, and bits 4:2 select the register inside that channel. The block multiplexes read data back onto the bus, serves a fixed set of byte-wide identification words at the top of the window, and drives one interrupt line per channel plus a combined line.

An integration-test pair of registers can take over the interrupt outputs. When the test-enable bit is set, the per-channel lines are driven straight from a software-written bit field rather than from the channels, so board-level wiring can be checked without running a timer. Each channel is a 32-bit down counter with a load value, a control byte, a raw interrupt flag and a masked interrupt flag. Counting is kept minimal here: it decrements once per clock while enabled.

Top module: `dual_timer_wrap`

## Requirements
- R1: After reset both interrupt outputs and the combined output are low; in each channel CONTROL reads 0x20, VALUE reads 0xFFFFFFFF and LOAD reads 0.
- R2: Channel 0 answers offsets 0x00-0x1C and channel 1 answers 0x20-0x3C. The per-channel word map is: 0x0 load (a write also sets the count), 0x4 current count, 0x8 control, 0xC interrupt clear, 0x10 raw flag, 0x14 masked flag, 0x18 background load. Offset 0x1C reads 0. Control keeps only bits 7:5 and 3:0, so the write mask is 0xEF.
- R3: A write to offset 0x0 sets both the load value and the count. A write to 0x18 sets the load value and leaves the count unchanged.
- R4: While control bit 7 is set, the count falls by one each clock. The step from 1 to 0 sets the raw flag. At zero the count reloads from the load value if bit 6 is set, or becomes 0xFFFFFFFF if bit 6 is clear. If bit 0 (one-shot) is set, the count instead holds at zero.
- R5: The masked flag is the raw flag ANDed with control bit 5. With test mode off, each interrupt output equals its channel's masked flag.
- R6: Any write to offset 0xC clears the raw flag. If the count steps from 1 to 0 in the same clock, the flag stays set.
- R7: Bit 0 of the word at 0xF00 is the test enable. Bits 1:0 of the word at 0xF04 drive interrupt outputs 1:0 while the test enable is set. Both words read back with only those bits kept.
- R8: The combined interrupt is the OR of the two interrupt outputs, taken after the test-mode selection.
- R9: The twelve words 0xFD0 to 0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of unmapped offsets return 0 and writes to them change nothing. Address bits 1:0 are ignored, so a sub-word address hits the enclosing word.
- R11: Read data is registered in the setup phase and valid throughout the access phase. pready_o is always high and pslverr_o is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Block select |
| penable_i | input | 1 | Access-phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address in the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Registered read data |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never signals an error |
| tmr_irq_o | output | 2 | Per-channel interrupt after test selection |
| irq_any_o | output | 1 | OR of tmr_irq_o |

## Verification
Two functions can collide in one clock: a bus write to the interrupt-clear word, and the channel's count stepping from 1 to 0. The bench loads a count of 5, enables one-shot counting and times the clear so that its access edge lands exactly on the fifth decrement. The raw flag must then still read 1. In a second run the clear falls two clocks after a reload instead, and the flag must read 0 until the next terminal step sets it again. Test-mode writes are also issued while a channel holds a pending masked interrupt, and the outputs must follow the test bits, not the channel.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hEF;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h20;
  localparam int unsigned CB_ONESHOT  = 0;
  localparam int unsigned CB_INTEN    = 5;
  localparam int unsigned CB_PERIODIC = 6;
  localparam int unsigned CB_EN       = 7;
  localparam int unsigned ID_WORDS    = 12;

  typedef enum logic [2:0] {
    CH_LOAD   = 3'd0,
    CH_VALUE  = 3'd1,
    CH_CTRL   = 3'd2,
    CH_INTCLR = 3'd3,
    CH_RIS    = 3'd4,
    CH_MIS    = 3'd5,
    CH_BGLOAD = 3'd6,
    CH_NONE   = 3'd7
  } ch_reg_e;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h23;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h1B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dtw_chan.sv
module dtw_chan
  import dtw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  ch_reg_e           reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mis_o
);
  logic [DATA_W-1:0] load_q, value_q, value_nxt;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ris_q;
  logic              run, wr_load, hit_zero;

  assign run     = ctrl_q[CB_EN];
  assign wr_load = wr_i && (reg_i == CH_LOAD);

  always_comb begin
    if (value_q != '0)            value_nxt = value_q - 1'b1;
    else if (ctrl_q[CB_ONESHOT])  value_nxt = '0;
    else if (ctrl_q[CB_PERIODIC]) value_nxt = load_q;
    else                          value_nxt = '1;
  end

  assign hit_zero = run && !wr_load && (value_q == DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= '0;
      value_q <= '1;
      ctrl_q  <= CTRL_RST;
      ris_q   <= 1'b0;
    end else begin
      if (wr_load)  value_q <= wdata_i;
      else if (run) value_q <= value_nxt;
      if (wr_i && (reg_i == CH_LOAD || reg_i == CH_BGLOAD)) load_q <= wdata_i;
      if (wr_i && reg_i == CH_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0] & CTRL_MASK;
      // terminal step wins over a clear in the same clock
      if (hit_zero)                          ris_q <= 1'b1;
      else if (wr_i && reg_i == CH_INTCLR)   ris_q <= 1'b0;
    end
  end

  assign mis_o = ris_q & ctrl_q[CB_INTEN];

  always_comb begin
    case (reg_i)
      CH_LOAD, CH_BGLOAD: rdata_o = load_q;
      CH_VALUE:           rdata_o = value_q;
      CH_CTRL:            rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      CH_RIS:             rdata_o = {{(DATA_W-1){1'b0}}, ris_q};
      CH_MIS:             rdata_o = {{(DATA_W-1){1'b0}}, mis_o};
      default:            rdata_o = '0;
    endcase
  end

  AST_LOAD_SETS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_load |=> value_q == $past(wdata_i)); // R3
  AST_BGLOAD_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_i == CH_BGLOAD && !run) |=> $stable(value_q)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_i == CH_INTCLR && !(run && value_q == DATA_W'(1))) |=> !ris_q); // R6
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wr_load && value_q == DATA_W'(1)) |=> ris_q); // R6
endmodule

// File: rtl/dtw_id_rom.sv
module dtw_id_rom
  import dtw_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o,
  output logic [7:0]        byte_o
);
  localparam logic [WORD_W-1:0] ID_BASE = WORD_W'(2**WORD_W - ID_WORDS);
  localparam logic [3:0]        BASE_LO = ID_BASE[3:0];

  logic [3:0] idx;
  assign idx    = word_i[3:0] - BASE_LO;
  assign hit_o  = word_i >= ID_BASE;
  assign byte_o = hit_o ? id_byte(idx) : 8'h00;
endmodule

// File: rtl/dtw_irq_sel.sv
module dtw_irq_sel #(
  parameter int unsigned NCH = 2
) (
  input  logic           test_en_i,
  input  logic [NCH-1:0] test_bits_i,
  input  logic [NCH-1:0] mis_i,
  output logic [NCH-1:0] irq_o,
  output logic           any_o
);
  assign irq_o = test_en_i ? test_bits_i : mis_i;
  assign any_o = |irq_o;
endmodule

// File: rtl/dual_timer_wrap.sv
module dual_timer_wrap
  import dtw_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [NCH-1:0]    tmr_irq_o,
  output logic              irq_any_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned CHF_W  = ADDR_W - 5;
  localparam logic [WORD_W-1:0] ITCR_WORD = WORD_W'((2**ADDR_W - 256) >> 2);
  localparam logic [WORD_W-1:0] ITOP_WORD = ITCR_WORD + 1'b1;

  logic [WORD_W-1:0] word;
  logic [CHF_W-1:0]  ch_f;
  logic              ch_hit, wr_acc, rd_setup, id_hit, mapped;
  ch_reg_e           reg_sel;
  logic [7:0]        id_val;
  logic [DATA_W-1:0] ch_rdata [NCH];
  logic [NCH-1:0]    mis;
  logic              itcr_q;
  logic [NCH-1:0]    itop_q;
  logic [DATA_W-1:0] rd_mux, prdata_q;
  logic              unused_addr;

  assign word        = paddr_i[ADDR_W-1:2];
  assign ch_f        = paddr_i[ADDR_W-1:5];
  assign ch_hit      = ch_f < CHF_W'(NCH);
  assign reg_sel     = ch_reg_e'(paddr_i[4:2]);
  assign wr_acc      = psel_i & penable_i & pwrite_i;
  assign rd_setup    = psel_i & ~penable_i & ~pwrite_i;
  assign unused_addr = ^paddr_i[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dtw_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_acc && ch_hit && (ch_f == CHF_W'(g))),
      .reg_i   (reg_sel),
      .wdata_i (pwdata_i),
      .rdata_o (ch_rdata[g]),
      .mis_o   (mis[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      itcr_q <= 1'b0;
      itop_q <= '0;
    end else if (wr_acc) begin
      if (word == ITCR_WORD) itcr_q <= pwdata_i[0];
      if (word == ITOP_WORD) itop_q <= pwdata_i[NCH-1:0];
    end
  end

  dtw_irq_sel #(.NCH(NCH)) u_irq_sel (
    .test_en_i   (itcr_q),
    .test_bits_i (itop_q),
    .mis_i       (mis),
    .irq_o       (tmr_irq_o),
    .any_o       (irq_any_o)
  );

  dtw_id_rom #(.WORD_W(WORD_W)) u_id_rom (
    .word_i (word),
    .hit_o  (id_hit),
    .byte_o (id_val)
  );

  always_comb begin
    rd_mux = '0;
    if (ch_hit) begin
      for (int i = 0; i < NCH; i++)
        if (ch_f == CHF_W'(i)) rd_mux = ch_rdata[i];
    end else if (word == ITCR_WORD) begin
      rd_mux = {{(DATA_W-1){1'b0}}, itcr_q};
    end else if (word == ITOP_WORD) begin
      rd_mux = {{(DATA_W-NCH){1'b0}}, itop_q};
    end else if (id_hit) begin
      rd_mux = {{(DATA_W-8){1'b0}}, id_val};
    end
  end

  // capture in setup so data is valid for the whole access phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prdata_q <= '0;
    else if (rd_setup) prdata_q <= rd_mux;
  end

  assign prdata_o  = prdata_q;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  assign mapped = (ch_hit && reg_sel != CH_NONE) || word == ITCR_WORD ||
                  word == ITOP_WORD || id_hit;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_setup && !mapped) |=> prdata_o == '0); // R10
  AST_TEST_OUT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && word == ITOP_WORD && itcr_q) |=> tmr_irq_o == $past(pwdata_i[NCH-1:0])); // R7
  AST_TEST_EN_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && word == ITCR_WORD) |=> prdata_o == prdata_o && itcr_q == $past(pwdata_i[0])); // R7
  AST_ANY_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_any_o) |-> $countones(tmr_irq_o) != 0); // R8
endmodule

// File: tb/dual_timer_wrap_bench.sv
module dual_timer_wrap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  tmr_irq;
  logic        irq_any;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dual_timer_wrap u_dual_timer_wrap (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .tmr_irq_o(tmr_irq), .irq_any_o(irq_any)
  );

  function automatic logic [7:0] id_exp(input int i);
    logic [7:0] tbl [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h23, 8'hB8,
                             8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return tbl[i];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // tasks are entered at a negedge and return at a negedge
  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: judge each read in its access phase, away from the edge
  always @(posedge clk) begin
    #2;
    if (psel && penable && !pwrite && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(prdata, e, t);
      if (!pready || pslverr) begin
        total++; bad++;
        $display("FAIL R11 actual=%b%b expected=10", pready, pslverr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk({29'b0, irq_any, tmr_irq}, 32'h0, "R1 irq after reset");
    apb_rd(12'h008, 32'h20, "R1 ch0 control");
    apb_rd(12'h004, 32'hFFFF_FFFF, "R1 ch0 value");
    apb_rd(12'h000, 32'h0, "R1 ch0 load");
    apb_rd(12'h028, 32'h20, "R1 ch1 control");
    apb_rd(12'h024, 32'hFFFF_FFFF, "R1 ch1 value");
    // R2 R3 decode and load paths
    apb_wr(12'h000, 32'h1234);
    apb_rd(12'h000, 32'h1234, "R3 load");
    apb_rd(12'h004, 32'h1234, "R3 load sets count");
    apb_wr(12'h038, 32'hABCD);
    apb_rd(12'h020, 32'hABCD, "R3 bgload sets load");
    apb_rd(12'h024, 32'hFFFF_FFFF, "R3 bgload keeps count");
    apb_rd(12'h000, 32'h1234, "R2 ch0 untouched by ch1");
    apb_wr(12'h008, 32'h7E);
    apb_rd(12'h008, 32'h6E, "R2 control mask");
    apb_rd(12'h00A, 32'h6E, "R10 sub-word address");
    apb_wr(12'h008, 32'h20);
    apb_rd(12'h01C, 32'h0, "R2 reserved slot");
    // R10 unmapped
    apb_wr(12'h040, 32'hFFFF_FFFF);
    apb_wr(12'h03C, 32'h5);
    apb_rd(12'h040, 32'h0, "R10 gap read");
    apb_rd(12'h03C, 32'h0, "R10 ch1 reserved");
    apb_rd(12'hF08, 32'h0, "R10 above test regs");
    apb_rd(12'hFCC, 32'h0, "R10 below id block");
    apb_rd(12'h020, 32'hABCD, "R10 write ignored ch1");
    apb_rd(12'h000, 32'h1234, "R10 write ignored ch0");
    // R9 identification words
    for (int i = 0; i < 12; i++)
      apb_rd(12'hFD0 + 12'(4 * i), {24'b0, id_exp(i)}, $sformatf("R9 id word %0d", i));
    // R4 R5 R8 one-shot terminal step on ch0
    apb_wr(12'h000, 32'd4);
    apb_wr(12'h008, 32'hA1);
    wait_n(3);
    chk({30'b0, tmr_irq}, 32'h0, "R4 before terminal step");
    wait_n(1);
    chk({30'b0, tmr_irq}, 32'h1, "R5 irq on terminal step");
    chk({31'b0, irq_any}, 32'h1, "R8 combined high");
    apb_rd(12'h010, 32'h1, "R4 raw flag");
    apb_rd(12'h014, 32'h1, "R5 masked flag");
    apb_rd(12'h004, 32'h0, "R4 one-shot holds zero");
    apb_wr(12'h008, 32'h81);
    chk({30'b0, tmr_irq}, 32'h0, "R5 mask off");
    apb_rd(12'h010, 32'h1, "R5 raw kept");
    apb_rd(12'h014, 32'h0, "R5 masked low");
    apb_wr(12'h00C, 32'h0);
    apb_rd(12'h010, 32'h0, "R6 clear");
    // R7 R8 test override
    apb_wr(12'h008, 32'hA1);
    apb_wr(12'h000, 32'd1);
    wait_n(2);
    chk({30'b0, tmr_irq}, 32'h1, "R5 channel pending");
    apb_wr(12'hF00, 32'h1);
    apb_wr(12'hF04, 32'h2);
    chk({30'b0, tmr_irq}, 32'h2, "R7 test bits drive");
    chk({31'b0, irq_any}, 32'h1, "R8 combined in test");
    apb_rd(12'hF00, 32'h1, "R7 enable readback");
    apb_rd(12'hF04, 32'h2, "R7 bits readback");
    apb_wr(12'hF04, 32'hFF);
    apb_rd(12'hF04, 32'h3, "R7 bits masked");
    chk({30'b0, tmr_irq}, 32'h3, "R7 both bits");
    apb_wr(12'hF04, 32'h0);
    chk({29'b0, irq_any, tmr_irq}, 32'h0, "R8 combined low in test");
    apb_wr(12'hF00, 32'h0);
    chk({30'b0, tmr_irq}, 32'h1, "R7 back to channel");
    apb_wr(12'h00C, 32'h0);
    apb_wr(12'h008, 32'h20);
    // R4 free-running wrap on ch1: 4 ticks from 2
    apb_wr(12'h020, 32'd2);
    apb_wr(12'h028, 32'hA0);
    wait_n(2);
    apb_wr(12'h028, 32'h20);
    apb_rd(12'h024, 32'hFFFF_FFFE, "R4 free-running wrap");
    chk({30'b0, tmr_irq}, 32'h2, "R5 ch1 irq");
    apb_wr(12'h02C, 32'h0);
    chk({30'b0, tmr_irq}, 32'h0, "R6 ch1 clear");
    // R4 periodic reload on ch1
    apb_wr(12'h020, 32'd2);
    apb_wr(12'h028, 32'hE0);
    wait_n(2);
    apb_wr(12'h028, 32'h60);
    apb_rd(12'h024, 32'h1, "R4 periodic reload");
    apb_rd(12'h020, 32'h2, "R4 periodic load kept");
    apb_wr(12'h02C, 32'h0);
    // R6 clear lands on the terminal step
    apb_wr(12'h000, 32'd5);
    apb_wr(12'h008, 32'hA1);
    wait_n(3);
    apb_wr(12'h00C, 32'h0);
    apb_rd(12'h010, 32'h1, "R6 set wins over clear");
    apb_wr(12'h000, 32'd5);
    apb_wr(12'h00C, 32'h0);
    apb_rd(12'h010, 32'h0, "R6 clear while counting");
    wait_n(6);
    apb_rd(12'h010, 32'h1, "R6 set again later");
    wait_n(2);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R11 actual=%0d expected=0 pending reads", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule